// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block decides what happens when the core issues one of four privileged instructions. The four are wait-for-interrupt, the supervisor address-translation fence, the hypervisor virtual-space fence and the hypervisor guest-space fence. The decode stage presents an instruction select with a one-cycle strobe, along with the following state:

- the current privilege level;
- the virtualization flag;
- whether the hart implements supervisor mode;
- four trap controls:
  - timeout-wait from machine status;
  - trap-virtual-memory from machine status;
  - virtual timeout-wait from hypervisor status;
  - virtual trap-virtual-memory from hypervisor status.

One cycle after the strobe the block reports exactly one outcome on a one-hot output:

- an illegal-instruction exception;
- a virtual-instruction exception;
- a halt request, which wait-for-interrupt can produce;
- a translation-cache flush request, which the fences can produce.

A cause code comes with the outcome so that the trap unit can load it directly. Illegal-instruction conditions are checked before virtual-instruction conditions for every instruction. The wakeup logic and the translation cache itself sit outside this block.

Top module: `priv_trap_check`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the outcome is 4'b0000 and the cause is 0.
- R2: The outcome is a registered one-hot vector that is valid on the cycle after a strobe. Its bits are:
  - bit0: illegal instruction;
  - bit1: virtual instruction;
  - bit2: halt;
  - bit3: flush.
  On the cycle after a cycle with no strobe the outcome is 4'b0000.
- R3: The cause is 2 when outcome bit0 is set and 22 when bit1 is set. It is 0 for halt, for flush and for no outcome.
- R4: Privilege encoding is U=2'b00, S=2'b01, M=2'b11. For wait-for-interrupt (select 0), the outcome is illegal in either of these cases:
  - timeout-wait is set and the hart is in S, or in U on a hart with no S mode;
  - the hart implements S mode and is in non-virtualized U.
- R5: When R4 does not make wait-for-interrupt illegal, the outcome is a virtual-instruction fault in either of these cases:
  - virtualized U;
  - virtualized S with virtual timeout-wait set.
  Otherwise the outcome is halt.
- R6: The supervisor fence (select 1) gives these outcomes, checked in this order:
  - illegal in U, or in S with trap-virtual-memory set;
  - otherwise a virtual-instruction fault when virtualized with virtual trap-virtual-memory set;
  - otherwise flush.
- R7: The hypervisor virtual fence (select 2) gives these outcomes:
  - a virtual-instruction fault in virtualized S;
  - flush in M or in non-virtualized S;
  - illegal otherwise.
- R8: The hypervisor guest fence (select 3) is illegal in non-virtualized S with trap-virtual-memory set. Otherwise it follows R7.
- R9: A strobe with select 4 to 7 gives illegal. The reserved privilege value 2'b10 gives illegal for every select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | One-cycle strobe that a privileged instruction is presented |
| instSel | input | 3 | Instruction select (0 wait, 1 supervisor fence, 2 hyp virtual fence, 3 hyp guest fence) |
| curPriv | input | 2 | Current privilege level |
| virtOn | input | 1 | Hart is running virtualized |
| hasSuper | input | 1 | Hart implements supervisor mode |
| mTimeoutWait | input | 1 | Machine timeout-wait control |
| mTrapVm | input | 1 | Machine trap-virtual-memory control |
| hTimeoutWait | input | 1 | Hypervisor virtual timeout-wait control |
| hTrapVm | input | 1 | Hypervisor virtual trap-virtual-memory control |
| outcome | output | 4 | One-hot outcome: illegal, virtual, halt, flush |
| causeCode | output | 5 | Exception cause for the outcome |

## Verification
The assertions check on every cycle the following properties:
- the outcome stays one-hot or zero;
- an idle cycle yields no outcome;
- the cause code agrees with the outcome bits;
- a handful of fixed decisions hold: user-mode supervisor fence, virtualized-supervisor hypervisor fence, unknown select and reserved privilege.

Whether each instruction's full priority chain is right over every combination of privilege, virtualization, supervisor presence and the four controls only shows up in the bench's exhaustive sweep. That sweep compares every result against an independent model.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int SEL_W   = 3;
  localparam int PRIV_W  = 2;
  localparam int CAUSE_W = 5;
  localparam int OUT_W   = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;

  localparam logic [PRIV_W-1:0] PRIV_USER  = 2'b00;
  localparam logic [PRIV_W-1:0] PRIV_SUPER = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_MACH  = 2'b11;

  typedef enum logic [SEL_W-1:0] {
    SEL_WAIT   = 3'd0,
    SEL_SFENCE = 3'd1,
    SEL_HVFENC = 3'd2,
    SEL_HGFENC = 3'd3
  } instSel_e;

  // Field order gives bit0 = illegal ... bit3 = flush when packed.
  typedef struct packed {
    logic flush;
    logic halt;
    logic virtFault;
    logic illegal;
  } ptcStrobes_t;
endpackage

// File: rtl/ptc_decide.sv
module ptc_decide
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [SEL_W-1:0]  instSel,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              virtOn,
  input  logic              hasSuper,
  input  logic              mTimeoutWait,
  input  logic              mTrapVm,
  input  logic              hTimeoutWait,
  input  logic              hTrapVm,
  output ptcStrobes_t       strobes
);
  logic inUser, inSuper, inMach, privBad;
  assign inUser  = (curPriv == PRIV_USER);
  assign inSuper = (curPriv == PRIV_SUPER);
  assign inMach  = (curPriv == PRIV_MACH);
  assign privBad = !(inUser || inSuper || inMach);

  // Per-instruction verdicts: illegal first, then virtual, else success.
  logic waitIll, waitVirt;
  logic sfIll, sfVirt;
  logic hvIll, hvVirt;
  logic hgIll, hgVirt;

  always_comb begin
    waitIll  = ((inSuper || (!hasSuper && inUser)) && mTimeoutWait) ||
               (hasSuper && inUser && !virtOn);
    waitVirt = virtOn && (inUser || (inSuper && hTimeoutWait));

    sfIll  = inUser || (inSuper && mTrapVm);
    sfVirt = virtOn && hTrapVm;

    hvVirt = inSuper && virtOn;
    hvIll  = !hvVirt && !(inMach || (inSuper && !virtOn));

    hgIll  = (inSuper && !virtOn && mTrapVm) || hvIll;
    hgVirt = hvVirt;
  end

  always_comb begin
    strobes = '0;
    if (instValid) begin
      if (privBad) begin
        strobes.illegal = 1'b1;
      end else begin
        unique case (instSel)
          SEL_WAIT: begin
            if (waitIll)       strobes.illegal   = 1'b1;
            else if (waitVirt) strobes.virtFault = 1'b1;
            else               strobes.halt      = 1'b1;
          end
          SEL_SFENCE: begin
            if (sfIll)         strobes.illegal   = 1'b1;
            else if (sfVirt)   strobes.virtFault = 1'b1;
            else               strobes.flush     = 1'b1;
          end
          SEL_HVFENC: begin
            if (hvVirt)        strobes.virtFault = 1'b1;
            else if (hvIll)    strobes.illegal   = 1'b1;
            else               strobes.flush     = 1'b1;
          end
          SEL_HGFENC: begin
            if (hgIll && !(inSuper && virtOn)) strobes.illegal = 1'b1;
            else if (hgVirt)   strobes.virtFault = 1'b1;
            else               strobes.flush     = 1'b1;
          end
          default:             strobes.illegal   = 1'b1;
        endcase
      end
    end
  end

  // R6: user-mode supervisor fence is always illegal
  a_r6_user_fence_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instSel == 3'd1 && curPriv == 2'b00) |-> strobes.illegal);

  // R7: virtualized supervisor hypervisor fence is a virtual fault
  a_r7_vs_hfence_virt: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instSel == 3'd2 && curPriv == 2'b01 && virtOn) |-> strobes.virtFault);

  // R9: unknown select or reserved privilege is illegal
  a_r9_unknown_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && (instSel > 3'd3 || curPriv == 2'b10)) |-> strobes.illegal);
endmodule

// File: rtl/ptc_outreg.sv
module ptc_outreg
  import ptc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  ptcStrobes_t        strobes,
  output logic [OUT_W-1:0]   outcome,
  output logic [CAUSE_W-1:0] causeCode
);
  logic [CAUSE_W-1:0] causeNext;

  always_comb begin
    causeNext = '0;
    if (strobes.illegal)        causeNext = CAUSE_ILLEGAL;
    else if (strobes.virtFault) causeNext = CAUSE_VIRT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outcome   <= '0;
      causeCode <= '0;
    end else begin
      outcome   <= strobes;
      causeCode <= causeNext;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outcome));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> (outcome == '0));

  a_r2_strobe_answers: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> ($countones(outcome) == 1));

  a_r3_cause_illegal: assert property (@(posedge clk) disable iff (!rstN)
    outcome[0] |-> (causeCode == 5'd2));

  a_r3_cause_virt: assert property (@(posedge clk) disable iff (!rstN)
    outcome[1] |-> (causeCode == 5'd22));

  a_r3_cause_none: assert property (@(posedge clk) disable iff (!rstN)
    !(outcome[0] || outcome[1]) |-> (causeCode == 5'd0));
endmodule

// File: rtl/priv_trap_check.sv
module priv_trap_check
  import ptc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instValid,
  input  logic [2:0]   instSel,
  input  logic [1:0]   curPriv,
  input  logic         virtOn,
  input  logic         hasSuper,
  input  logic         mTimeoutWait,
  input  logic         mTrapVm,
  input  logic         hTimeoutWait,
  input  logic         hTrapVm,
  output logic [3:0]   outcome,
  output logic [4:0]   causeCode
);
  ptcStrobes_t strobes;

  ptc_decide decide_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instSel(instSel),
    .curPriv(curPriv), .virtOn(virtOn), .hasSuper(hasSuper),
    .mTimeoutWait(mTimeoutWait), .mTrapVm(mTrapVm),
    .hTimeoutWait(hTimeoutWait), .hTrapVm(hTrapVm), .strobes(strobes)
  );

  ptc_outreg outreg_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .strobes(strobes),
    .outcome(outcome), .causeCode(causeCode)
  );
endmodule

// File: tb/priv_trap_check_tb_top.sv
module priv_trap_check_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [2:0] instSel = '0;
  logic [1:0] curPriv = '0;
  logic virtOn = 1'b0, hasSuper = 1'b0;
  logic mTimeoutWait = 1'b0, mTrapVm = 1'b0, hTimeoutWait = 1'b0, hTrapVm = 1'b0;
  logic [3:0] outcome;
  logic [4:0] causeCode;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  priv_trap_check dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instSel(instSel),
    .curPriv(curPriv), .virtOn(virtOn), .hasSuper(hasSuper),
    .mTimeoutWait(mTimeoutWait), .mTrapVm(mTrapVm),
    .hTimeoutWait(hTimeoutWait), .hTrapVm(hTrapVm),
    .outcome(outcome), .causeCode(causeCode)
  );

  localparam logic [3:0] O_ILL = 4'd1, O_VIRT = 4'd2, O_HALT = 4'd4, O_FLUSH = 4'd8;

  // Independent model taken from the requirement text.
  function automatic logic [3:0] model(input int sel, input int p, input bit v,
                                       input bit hs, input bit tw, input bit tvm,
                                       input bit vtw, input bit vtvm);
    bit u = (p == 0), s = (p == 1), m = (p == 3);
    if (p == 2 || sel > 3) return O_ILL;                            // R9
    case (sel)
      0: begin                                                       // R4 / R5
        if (tw && (s || (u && !hs))) return O_ILL;
        if (hs && u && !v) return O_ILL;
        if (v && u) return O_VIRT;
        if (v && s && vtw) return O_VIRT;
        return O_HALT;
      end
      1: begin                                                       // R6
        if (u) return O_ILL;
        if (s && tvm) return O_ILL;
        if (v && vtvm) return O_VIRT;
        return O_FLUSH;
      end
      default: begin                                                 // R7 / R8
        if (sel == 3 && s && !v && tvm) return O_ILL;
        if (s && v) return O_VIRT;
        if (m || s) return O_FLUSH;
        return O_ILL;
      end
    endcase
  endfunction

  function automatic string tagOf(input int sel, input int p);
    if (p == 2 || sel > 3) return "R9";
    case (sel)
      0: return "R4/R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic [3:0] expO);
    logic [4:0] expC;
    expC = (expO == O_ILL) ? 5'd2 : (expO == O_VIRT) ? 5'd22 : 5'd0;
    nRun++;
    if (outcome !== expO) begin
      nFail++;
      $display("FAIL %s outcome actual=%b expected=%b", tag, outcome, expO);
    end
    nRun++;
    if (causeCode !== expC) begin
      nFail++;
      $display("FAIL R3 (%s) cause actual=%0d expected=%0d", tag, causeCode, expC);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 in reset", 4'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 4'd0);

    // Exhaustive sweep: strobe at one negedge, check at the next.
    for (int sel = 0; sel < 8; sel++)
      for (int p = 0; p < 4; p++)
        for (int f = 0; f < 64; f++) begin
          instValid = 1'b1;
          instSel = 3'(sel);
          curPriv = 2'(p);
          {virtOn, hasSuper, mTimeoutWait, mTrapVm, hTimeoutWait, hTrapVm} = 6'(f);
          @(negedge clk);
          checkOut(tagOf(sel, p), model(sel, p, f[5], f[4], f[3], f[2], f[1], f[0]));
          if (f % 16 == 5) begin
            instValid = 1'b0; // R2: idle cycle gives no outcome
            @(negedge clk);
            checkOut("R2 idle", 4'd0);
          end
        end

    instValid = 1'b0;
    @(negedge clk);
    checkOut("R2 final idle", 4'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule